// File: doc/BRIEF.md
# Checkstop Source and Enable Register

A 32-bit control register that gathers a processor's checkstop error sources. Each of the fifteen error-condition inputs has a pair of bits: an enable bit and a latched source bit. When a condition is present while its enable bit is on, the source bit latches and stays set. While any source bit is set, a registered checkstop request output is driven high one clock later. Software reads the whole register combinationally. It writes the whole register through a single move-to-special-register write strobe. Enable bits and the snoop-mode bit take whatever is written. A written 0 clears a source bit. A written 1 to a source bit does nothing, so software can never raise a checkstop by hand.

A synchronous hard reset loads a fixed value. The main-cache error flag in that value comes from a power-on self-test result input, and that input is sampled only while hard reset is high. The snoop-mode bit is brought out as a plain control pin. It selects how the high-priority snoop request line and its reserved queue slot are used. The interface is plain control and status: there is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `csr_checkstop_reg`

## Requirements
- R1: While `hard_rst` is high at a clock edge, the register loads `RESET_VAL` (default 0x80010080), with bit 1 replaced by `bist_fail`, and `checkstop_req` goes low. With the default value this reads 0x80010080 when `bist_fail`=0 and 0x80010082 when `bist_fail`=1.
- R2: Field layout, with data bit 0 as the least significant bit:
  - For condition i < 14, the enable bit is `data[16-i]` and the source bit is `data[30-i]`.
  - For condition 14, the enable bit is `data[31]` and the source bit is `data[2]`.
  - Bit 1 is the cache error flag and bit 0 is the snoop mode. `rd_data` shows the current register contents.
- R3: A write (`sw_we`=1) takes `sw_wdata` into every enable bit and into the snoop-mode bit, with no restriction.
- R4: A source bit sets at a clock edge only if its `err_cond` bit is 1 and the enable bit held before that edge is 1. A written 1 to a source bit never sets it.
- R5: A source bit that is set stays set until a write carries 0 in its position, even after its condition goes away.
- R6: When a write clears a source bit and its qualifying condition is present in the same cycle, the bit stays set. A bit that is cleared while its condition is still present sets again on the next edge.
- R7: `checkstop_req` is high in the cycle after an edge at which any source bit was set, and low otherwise.
- R8: Outside hard reset, `bist_fail` and writes to bit 1 have no effect on the cache error flag.
- R9: `snoop_hp_en` equals the snoop-mode bit: 1 enables the high-priority snoop request line, and 0 disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, active high |
| bist_fail | input | 1 | Power-on cache self-test failed; sampled only during reset |
| err_cond | input | 15 | Error condition inputs, one per source |
| sw_we | input | 1 | Software register write strobe |
| sw_wdata | input | 32 | Software write data |
| rd_data | output | 32 | Current register contents |
| checkstop_req | output | 1 | Registered OR of all latched source bits |
| snoop_hp_en | output | 1 | High-priority snoop request mode |

## Verification
The bench builds the block with its default reset value of 0x80010080. That value has enable bits on for conditions 0, 9 and 14 and off for the rest, so right after reset both the gated and the ungated cases of the source latch can be reached without any write. Directed cases cover a written 1 to the sources, a clear racing a live condition, and a toggling self-test input outside reset. Seeded random writes and conditions then run against a bench model of the register.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int REG_W    = 32;
  localparam int N_COND   = 15;
  localparam int MODE_POS = 0;
  localparam int ERR_POS  = 1;

  function automatic int en_pos(input int i);
    return (i < N_COND - 1) ? 16 - i : 31;
  endfunction

  function automatic int src_pos(input int i);
    return (i < N_COND - 1) ? 30 - i : 2;
  endfunction

  function automatic logic [N_COND-1:0] pick_en(input logic [REG_W-1:0] v);
    logic [N_COND-1:0] r;
    for (int i = 0; i < N_COND; i++) r[i] = v[en_pos(i)];
    return r;
  endfunction

  function automatic logic [N_COND-1:0] pick_src(input logic [REG_W-1:0] v);
    logic [N_COND-1:0] r;
    for (int i = 0; i < N_COND; i++) r[i] = v[src_pos(i)];
    return r;
  endfunction
endpackage

// File: rtl/csr_src_bank.sv
module csr_src_bank #(
  parameter int N = 15,
  parameter logic [N-1:0] RST_SRC = '0
) (
  input  logic         clk,
  input  logic         hard_rst,
  input  logic [N-1:0] cond,
  input  logic [N-1:0] en,
  input  logic         wr,
  input  logic [N-1:0] wr_keep,
  output logic [N-1:0] src
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic clr;
    assign clr = wr & ~wr_keep[i];
    always_ff @(posedge clk) begin
      if (hard_rst) src[i] <= RST_SRC[i];
      else          src[i] <= (src[i] & ~clr) | (cond[i] & en[i]);
    end

    // R4
    src_set_gated_chk: assert property (@(posedge clk) disable iff (hard_rst)
      $past(!hard_rst) && !src[i] && !(cond[i] && en[i]) |=> !src[i]);
    // R6
    cond_wins_chk: assert property (@(posedge clk) disable iff (hard_rst)
      cond[i] && en[i] |=> src[i]);
    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (hard_rst)
      src[i] && !(wr && !wr_keep[i]) |=> src[i]);
  end
endmodule

// File: rtl/csr_ctl_fields.sv
module csr_ctl_fields #(
  parameter int N = 15,
  parameter logic [N-1:0] RST_EN = '0,
  parameter logic RST_MODE = 1'b0
) (
  input  logic         clk,
  input  logic         hard_rst,
  input  logic         bist_fail,
  input  logic         wr,
  input  logic [N-1:0] wr_en_bits,
  input  logic         wr_mode,
  output logic [N-1:0] en,
  output logic         mode,
  output logic         cache_err
);
  always_ff @(posedge clk) begin
    if (hard_rst) begin
      en        <= RST_EN;
      mode      <= RST_MODE;
      cache_err <= bist_fail;
    end else if (wr) begin
      en   <= wr_en_bits;
      mode <= wr_mode;
    end
  end

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (hard_rst)
    $past(!hard_rst) |-> $stable(cache_err));
  // R3
  en_write_chk: assert property (@(posedge clk) disable iff (hard_rst)
    wr |=> en == $past(wr_en_bits));
endmodule

// File: rtl/csr_checkstop_reg.sv
module csr_checkstop_reg
  import csr_pkg::*;
#(
  parameter logic [REG_W-1:0] RESET_VAL = 32'h8001_0080
) (
  input  logic              clk,
  input  logic              hard_rst,
  input  logic              bist_fail,
  input  logic [N_COND-1:0] err_cond,
  input  logic              sw_we,
  input  logic [REG_W-1:0]  sw_wdata,
  output logic [REG_W-1:0]  rd_data,
  output logic              checkstop_req,
  output logic              snoop_hp_en
);
  localparam logic [N_COND-1:0] RST_EN  = pick_en(RESET_VAL);
  localparam logic [N_COND-1:0] RST_SRC = pick_src(RESET_VAL);

  logic [N_COND-1:0] en, src, wr_en_bits, wr_src_bits;
  logic mode, cache_err;
  logic unused_err_wbit;

  assign wr_en_bits      = pick_en(sw_wdata);
  assign wr_src_bits     = pick_src(sw_wdata);
  assign unused_err_wbit = sw_wdata[ERR_POS];

  csr_ctl_fields #(.N(N_COND), .RST_EN(RST_EN), .RST_MODE(RESET_VAL[MODE_POS])) u_ctl (
    .clk(clk), .hard_rst(hard_rst), .bist_fail(bist_fail), .wr(sw_we),
    .wr_en_bits(wr_en_bits), .wr_mode(sw_wdata[MODE_POS]),
    .en(en), .mode(mode), .cache_err(cache_err));

  csr_src_bank #(.N(N_COND), .RST_SRC(RST_SRC)) u_src (
    .clk(clk), .hard_rst(hard_rst), .cond(err_cond), .en(en),
    .wr(sw_we), .wr_keep(wr_src_bits), .src(src));

  always_ff @(posedge clk) begin
    if (hard_rst) checkstop_req <= 1'b0;
    else          checkstop_req <= |src;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_COND; i++) begin
      rd_data[en_pos(i)]  = en[i];
      rd_data[src_pos(i)] = src[i];
    end
    rd_data[MODE_POS] = mode;
    rd_data[ERR_POS]  = cache_err;
  end

  assign snoop_hp_en = mode;

  // R7
  req_follows_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (src != '0) |=> checkstop_req);
  // R7
  req_quiet_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (src == '0) |=> !checkstop_req);
endmodule

// File: tb/test_csr_checkstop_reg.sv
module test_csr_checkstop_reg;
  logic clk = 1'b0;
  logic hard_rst = 1'b1, bist_fail = 1'b0, sw_we = 1'b0;
  logic [14:0] err_cond = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] rd_data;
  logic checkstop_req, snoop_hp_en;

  int tests = 0, fails = 0;
  logic [14:0] m_en, m_src;
  logic m_mode, m_err, m_req;

  always #5 clk = ~clk;

  csr_checkstop_reg i_csr_checkstop_reg (
    .clk(clk), .hard_rst(hard_rst), .bist_fail(bist_fail), .err_cond(err_cond),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .rd_data(rd_data),
    .checkstop_req(checkstop_req), .snoop_hp_en(snoop_hp_en));

  function automatic int epos(int i); return (i < 14) ? 16 - i : 31; endfunction
  function automatic int spos(int i); return (i < 14) ? 30 - i : 2; endfunction

  function automatic logic [31:0] pack(logic [14:0] e, logic [14:0] s, logic md, logic er);
    logic [31:0] v = '0;
    for (int i = 0; i < 15; i++) begin v[epos(i)] = e[i]; v[spos(i)] = s[i]; end
    v[0] = md; v[1] = er;
    return v;
  endfunction

  function automatic logic [14:0] wsrc(logic [31:0] w);
    logic [14:0] r;
    for (int i = 0; i < 15; i++) r[i] = w[spos(i)];
    return r;
  endfunction

  function automatic logic [14:0] wen(logic [31:0] w);
    logic [14:0] r;
    for (int i = 0; i < 15; i++) r[i] = w[epos(i)];
    return r;
  endfunction

  task automatic model_edge();
    if (hard_rst) begin
      m_en = wen(32'h8001_0080); m_src = wsrc(32'h8001_0080);
      m_mode = 1'b0; m_err = bist_fail; m_req = 1'b0;
    end else begin
      m_req = |m_src;
      m_src = (sw_we ? (m_src & wsrc(sw_wdata)) : m_src) | (err_cond & m_en);
      if (sw_we) begin m_en = wen(sw_wdata); m_mode = sw_wdata[0]; end
    end
  endtask

  task automatic check(string req);
    logic [31:0] exp = pack(m_en, m_src, m_mode, m_err);
    tests++;
    if (rd_data !== exp) begin
      fails++; $display("FAIL %s rd_data actual %h expected %h", req, rd_data, exp);
    end
    tests++;
    if (checkstop_req !== m_req || snoop_hp_en !== m_mode) begin
      fails++;
      $display("FAIL %s req/mode actual %b%b expected %b%b", req,
               checkstop_req, snoop_hp_en, m_req, m_mode);
    end
  endtask

  task automatic step(string req, logic hr, logic bf, logic [14:0] c, logic we, logic [31:0] wd);
    hard_rst = hr; bist_fail = bf; err_cond = c; sw_we = we; sw_wdata = wd;
    @(posedge clk); model_edge();
    @(negedge clk); check(req);
  endtask

  initial begin
    #2000000;
    fails++; $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned r;
    logic [31:0] w;
    r = $urandom(32'd4242);
    @(negedge clk);
    // R1 reset with passing and failing self test
    step("R1", 1, 0, '0, 0, '0);
    tests++; if (rd_data !== 32'h8001_0080) begin fails++; $display("FAIL R1 actual %h expected 80010080", rd_data); end
    step("R1", 1, 1, '0, 0, '0);
    tests++; if (rd_data !== 32'h8001_0082) begin fails++; $display("FAIL R1 actual %h expected 80010082", rd_data); end
    // R8 self-test input toggling outside reset, write to bit 1
    step("R8", 0, 0, '0, 0, '0);
    step("R8", 0, 1, '0, 1, 32'h8001_0080);
    tests++; if (rd_data[1] !== 1'b1) begin fails++; $display("FAIL R8 actual %b expected 1", rd_data[1]); end
    step("R1", 1, 0, '0, 0, '0);
    // R4 condition with enable off (cond 1) has no effect; written ones to sources ignored
    step("R4", 0, 0, 15'h0002, 0, '0);
    step("R4", 0, 0, '0, 1, 32'h8001_0080 | pack('0, '1, 0, 0));
    tests++; if (wsrc(rd_data) !== '0) begin fails++; $display("FAIL R4 src actual %h expected 0", wsrc(rd_data)); end
    // R2 R7 condition 0 enabled at data[16], source at data[30]
    step("R2", 0, 0, 15'h0001, 0, '0);
    tests++; if (rd_data[30] !== 1'b1 || checkstop_req !== 1'b0) begin fails++; $display("FAIL R2 actual %b%b expected 10", rd_data[30], checkstop_req); end
    step("R7", 0, 0, '0, 0, '0);
    tests++; if (checkstop_req !== 1'b1) begin fails++; $display("FAIL R7 actual %b expected 1", checkstop_req); end
    // R5 sticky after condition gone
    step("R5", 0, 0, '0, 0, '0);
    // R6 clear racing live condition keeps bit
    step("R6", 0, 0, 15'h0001, 1, 32'h8001_0080);
    tests++; if (rd_data[30] !== 1'b1) begin fails++; $display("FAIL R6 actual %b expected 1", rd_data[30]); end
    step("R5", 0, 0, '0, 1, 32'h8001_0080);
    tests++; if (rd_data[30] !== 1'b0) begin fails++; $display("FAIL R5 clear actual %b expected 0", rd_data[30]); end
    step("R7", 0, 0, '0, 0, '0);
    // R3 R9 write all enables and mode
    step("R3", 0, 0, '0, 1, pack('1, '0, 1, 0));
    step("R9", 0, 0, 15'h4000, 0, '0);
    tests++; if (rd_data[2] !== 1'b1 || snoop_hp_en !== 1'b1) begin fails++; $display("FAIL R9 actual %b%b expected 11", rd_data[2], snoop_hp_en); end
    // random mix
    for (int k = 0; k < 400; k++) begin
      w = $urandom;
      step("R5", 0, $urandom_range(0, 1), (($urandom_range(0, 3) == 0) ? 15'($urandom) : '0),
           ($urandom_range(0, 2) == 0), w);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule